// File: doc/BRIEF.md
# Wide Add/Subtract Unit with Flag Groups

This unit is the 256-bit add and subtract datapath of a big-number coprocessor. Each operation takes two wide operands. The second operand first passes through a logical shifter that moves it by a whole number of bytes. The operation then produces a registered 256-bit result one cycle later. Plain adds and subtracts record carry/borrow, least significant bit, most significant bit and zero in one of two four-bit flag groups. A one-bit field on the request picks which group is written.

The unit also holds the 256-bit modulus used by the modular add and subtract operations. Software can write the modulus in two ways: as a single wide special register, or one 32-bit word at a time through eight control registers. Both flag groups are packed into one 8-bit control register that can be read and written. A write to that register overrides any arithmetic flag update in the same cycle.

Top module: `wide_addsub_flags`

## Requirements
- R1: Operation code 0 (add) yields `res_q = (a + b') mod 2^256`, where b' is the shifted second operand. The C flag of the selected group is set to the carry out of bit 255.
- R2: Operation code 1 (add with carry) adds the C flag of the selected group as carry in. C is then set to the new carry out.
- R3: Operation code 2 (subtract) yields `a - b'`. Operation code 3 (subtract with borrow) yields `a - b' - C`. In both cases C is set to 1 exactly when the true difference is negative (borrow).
- R4: After codes 0 to 3, the selected group holds C in bit 0, the result's bit 0 in bit 1 (L), its bit 255 in bit 2 (M), and 1 in bit 3 (Z) when the result is zero. The other group does not change. With `op_valid` low, no flag changes.
- R5: With `shift_dir` = 0, b is shifted left by 8·`shift_bytes` bits. With `shift_dir` = 1, it is shifted right by the same amount. Vacated bits are zero.
- R6: Operation code 4 (modular add) forms the 257-bit sum a + b'. It subtracts the modulus once if the sum is at least the modulus, and returns the low 256 bits.
- R7: Operation code 5 (modular subtract) forms a - b'. It adds the modulus once if a < b', and returns the result modulo 2^256.
- R8: Operation codes 4 and 5 leave both flag groups unchanged.
- R9: Control register 0x7C0 reads as the packed flags: group 0 in bits 3:0 and group 1 in bits 7:4, with bits 31:8 reading zero. A write loads bits 7:0 into the flags.
- R10: A flags-register write in the same cycle as an arithmetic operation wins. The flags take the written value, while the result is still produced.
- R11: A wide write (`wide_we`) loads the whole modulus. A control write to 0x7D0+k (k = 0..7) loads modulus bits [32k+31:32k] only. Reads of those addresses return the same words. Other addresses read zero.
- R12: `res_valid` is high in exactly the cycle after `op_valid`. `res_q` changes only then and otherwise holds.
- R13: Reset clears the result, `res_valid`, both flag groups and the modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request this cycle |
| op_kind | input | 3 | 0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 mod add, 5 mod sub |
| op_grp | input | 1 | Flag group used and updated |
| op_a | input | 256 | First operand |
| op_b | input | 256 | Second operand, before shifting |
| shift_dir | input | 1 | 0 left, 1 right |
| shift_bytes | input | 5 | Shift distance in bytes |
| res_q | output | 256 | Registered result |
| res_valid | output | 1 | Result updated this cycle |
| flags_o | output | 8 | Packed flag groups |
| mod_o | output | 256 | Current modulus |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | 12 | Control register number |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register read data (combinational) |
| wide_we | input | 1 | Wide modulus write strobe |
| wide_wdata | input | 256 | Wide modulus write data |

## Verification
The plain add is tried with small values, which separates a working sum from a stuck carry. It is also tried with all-ones plus one, which exercises the carry out of bit 255, the zero flag and the MSB flag together. Subtracts are run with both signs of the difference, and with and without an incoming borrow, to show that C is reported as a borrow rather than the raw carry. The modular ops are driven below, at and above the modulus, including sums that overflow 256 bits, so the single correction step is seen to fire only when needed. Shifts are tried at distance zero, at one byte and at the maximum in each direction, with patterns whose shifted-out bytes would be visible if the fill were wrong.

// File: rtl/wide_addsub_flags.sv
module wide_addsub_flags #(
  parameter int W         = 256,
  parameter int CW        = 32,
  parameter int AW        = 12,
  parameter int SHW       = $clog2(W / 8),
  parameter logic [AW-1:0] FLAG_ADDR = 12'h7C0,
  parameter logic [AW-1:0] MOD_BASE  = 12'h7D0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_kind,
  input  logic           op_grp,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           shift_dir,
  input  logic [SHW-1:0] shift_bytes,
  output logic [W-1:0]   res_q,
  output logic           res_valid,
  output logic [7:0]     flags_o,
  output logic [W-1:0]   mod_o,
  input  logic           csr_we,
  input  logic [AW-1:0]  csr_addr,
  input  logic [CW-1:0]  csr_wdata,
  output logic [CW-1:0]  csr_rdata,
  input  logic           wide_we,
  input  logic [W-1:0]   wide_wdata
);
  localparam int NWORD = W / CW;
  localparam int SAW   = SHW + 3;

  logic [7:0]   flags_q;
  logic [W-1:0] mod_q;
  logic [W-1:0] b_sh;
  logic [SAW-1:0] sh_amt;
  logic [3:0]   grp_cur;
  logic         c_in;
  logic         is_sub, is_mod, flag_wr;
  logic [W:0]   sum;
  logic [W:0]   msum;
  logic [W:0]   mred;
  logic [W-1:0] res_d;
  logic         c_out;
  logic [3:0]   grp_new;

  assign sh_amt  = {shift_bytes, 3'b000};
  assign b_sh    = shift_dir ? (op_b >> sh_amt) : (op_b << sh_amt);
  assign grp_cur = op_grp ? flags_q[7:4] : flags_q[3:0];
  assign c_in    = grp_cur[0];
  assign is_sub  = (op_kind == 3'd2) || (op_kind == 3'd3) || (op_kind == 3'd5);
  assign is_mod  = (op_kind == 3'd4) || (op_kind == 3'd5);
  assign flag_wr = csr_we && (csr_addr == FLAG_ADDR);

  always_comb begin
    logic cin_bit;
    case (op_kind)
      3'd1:    cin_bit = c_in;
      3'd2:    cin_bit = 1'b1;
      3'd3:    cin_bit = ~c_in;
      3'd5:    cin_bit = 1'b1;
      default: cin_bit = 1'b0;
    endcase
    sum = {1'b0, op_a} + {1'b0, (is_sub ? ~b_sh : b_sh)} + {{W{1'b0}}, cin_bit};
  end

  assign c_out = is_sub ? ~sum[W] : sum[W];

  always_comb begin
    msum = sum;
    mred = sum;
    if (op_kind == 3'd4) begin
      mred = sum - {1'b0, mod_q};
      if (sum >= {1'b0, mod_q}) msum = mred;
    end else if (op_kind == 3'd5) begin
      mred = sum + {1'b0, mod_q};
      if (!sum[W]) msum = mred;
    end
  end

  assign res_d   = msum[W-1:0];
  assign grp_new = {(res_d == '0), res_d[W-1], res_d[0], c_out};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_wr) begin
      flags_q <= csr_wdata[7:0];
    end else if (op_valid && !is_mod) begin
      if (op_grp) flags_q[7:4] <= grp_new;
      else        flags_q[3:0] <= grp_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
    end else begin
      if (wide_we) mod_q <= wide_wdata;
      for (int k = 0; k < NWORD; k++)
        if (csr_we && (csr_addr == MOD_BASE + AW'(k)))
          mod_q[k*CW +: CW] <= csr_wdata;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == FLAG_ADDR) csr_rdata = {{(CW-8){1'b0}}, flags_q};
    for (int k = 0; k < NWORD; k++)
      if (csr_addr == MOD_BASE + AW'(k)) csr_rdata = mod_q[k*CW +: CW];
  end

  assign flags_o = flags_q;
  assign mod_o   = mod_q;
endmodule

// File: rtl/wide_addsub_flags_chk.sv
module wide_addsub_flags_chk #(
  parameter int W   = 256,
  parameter int CW  = 32,
  parameter int AW  = 12,
  parameter int SHW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [2:0]     op_kind,
  input logic           op_grp,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [SHW-1:0] shift_bytes,
  input logic [W-1:0]   res_q,
  input logic           res_valid,
  input logic [7:0]     flags_o,
  input logic [W-1:0]   mod_o,
  input logic           csr_we,
  input logic [AW-1:0]  csr_addr,
  input logic [CW-1:0]  csr_wdata,
  input logic           wide_we
);
  logic fw, mw, plain;
  assign fw    = csr_we && (csr_addr == 12'h7C0);
  assign mw    = wide_we || (csr_we && (csr_addr[AW-1:3] == 9'h0FA));
  assign plain = op_kind < 3'd4;

  p_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_q)));
  p_flag_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fw |=> (flags_o == $past(csr_wdata[7:0])));
  p_grp0_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && plain && !op_grp && !fw) |=>
      ($stable(flags_o[7:4]) && flags_o[1] == res_q[0] &&
       flags_o[2] == res_q[W-1] && flags_o[3] == (res_q == '0)));
  p_grp1_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && plain && op_grp && !fw) |=>
      ($stable(flags_o[3:0]) && flags_o[5] == res_q[0] &&
       flags_o[6] == res_q[W-1] && flags_o[7] == (res_q == '0)));
  p_idle_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !fw) |=> $stable(flags_o));
  p_mod_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !plain && op_kind != 3'd6 && op_kind != 3'd7 && !fw) |=> $stable(flags_o));
  p_modadd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4 && shift_bytes == '0 && op_a < mod_o &&
     op_b < mod_o && !mw) |=> (res_q < mod_o));
  p_mod_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mw |=> $stable(mod_o));
endmodule

bind wide_addsub_flags wide_addsub_flags_chk #(.W(W), .CW(CW), .AW(AW), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_grp(op_grp),
  .op_a(op_a), .op_b(op_b), .shift_bytes(shift_bytes), .res_q(res_q),
  .res_valid(res_valid), .flags_o(flags_o), .mod_o(mod_o), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_wdata(csr_wdata), .wide_we(wide_we)
);

// File: tb/wide_addsub_flags_test.sv
`timescale 1ns/1ps
module wide_addsub_flags_test;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_grp = 0, shift_dir = 0, csr_we = 0, wide_we = 0;
  logic [2:0] op_kind = 0;
  logic [255:0] op_a = 0, op_b = 0, wide_wdata = 0;
  logic [4:0] shift_bytes = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic [255:0] res_q, mod_o;
  logic res_valid;
  logic [7:0] flags_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_flags = 0;
  logic [255:0] exp_mod = 0;
  localparam logic [255:0] ONES = {256{1'b1}};

  always #2.5 clk = ~clk;

  wide_addsub_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_grp(op_grp),
    .op_a(op_a), .op_b(op_b), .shift_dir(shift_dir), .shift_bytes(shift_bytes),
    .res_q(res_q), .res_valid(res_valid), .flags_o(flags_o), .mod_o(mod_o),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .wide_we(wide_we), .wide_wdata(wide_wdata)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] shf(input logic [255:0] b, input logic dir, input logic [4:0] nb);
    logic [255:0] r = b;
    for (int i = 0; i < nb; i++) r = dir ? {8'h00, r[255:8]} : {r[247:0], 8'h00};
    return r;
  endfunction

  task automatic do_op(input logic [2:0] kind, input logic grp, input logic [255:0] a,
                       input logic [255:0] b, input logic dir, input logic [4:0] nb,
                       input string req, input logic fwr = 0, input logic [7:0] fval = 0);
    logic [255:0] bs = shf(b, dir, nb);
    logic c = exp_flags[grp*4];
    logic [256:0] wa = {1'b0, a}, wb = {1'b0, bs}, s;
    logic [255:0] r;
    logic cf;
    case (kind)
      3'd0: begin s = wa + wb; r = s[255:0]; cf = s[256]; end
      3'd1: begin s = wa + wb + c; r = s[255:0]; cf = s[256]; end
      3'd2: begin r = a - bs; cf = (wa < wb); end
      3'd3: begin r = a - bs - c; cf = (wa < wb + c); end
      3'd4: begin s = wa + wb; if (s >= {1'b0, exp_mod}) s = s - {1'b0, exp_mod}; r = s[255:0]; cf = 0; end
      default: begin r = (a >= bs) ? a - bs : a - bs + exp_mod; cf = 0; end
    endcase
    @(negedge clk);
    op_valid = 1; op_kind = kind; op_grp = grp; op_a = a; op_b = b;
    shift_dir = dir; shift_bytes = nb;
    if (fwr) begin csr_we = 1; csr_addr = 12'h7C0; csr_wdata = {24'h0, fval}; end
    @(negedge clk);
    op_valid = 0; csr_we = 0;
    if (fwr) exp_flags = fval;
    else if (kind < 3'd4) exp_flags[grp*4 +: 4] = {(r == 0), r[255], r[0], cf};
    chk({req, " result"}, res_q, r);
    chk({req, " flags"}, {248'h0, flags_o}, {248'h0, exp_flags});
    chk("R12 valid", {255'h0, res_valid}, 256'd1);
  endtask

  task automatic wr_csr(input logic [11:0] addr, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = addr; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
    if (addr == 12'h7C0) exp_flags = d[7:0];
    if (addr >= 12'h7D0 && addr <= 12'h7D7) exp_mod[(addr - 12'h7D0)*32 +: 32] = d;
  endtask

  task automatic rd_csr(input logic [11:0] addr, input logic [31:0] exp, input string req);
    csr_addr = addr; #0.5;
    chk(req, {224'h0, csr_rdata}, {224'h0, exp});
  endtask

  task automatic t_reset;
    chk("R13 result", res_q, 0);
    chk("R13 valid", {255'h0, res_valid}, 0);
    chk("R13 flags", {248'h0, flags_o}, 0);
    chk("R13 mod", mod_o, 0);
  endtask

  task automatic t_add;
    do_op(0, 0, 256'd5, 256'd7, 0, 0, "R1 small");
    do_op(0, 0, ONES, 256'd1, 0, 0, "R1 wrap carry zero");
    do_op(0, 1, {64{4'hA}}, {64{4'h5}}, 0, 0, "R1 alternating M");
  endtask

  task automatic t_addc;
    wr_csr(12'h7C0, 32'h0000_0010);
    rd_csr(12'h7C0, 32'h10, "R9 read flags");
    do_op(1, 1, 256'd10, 256'd20, 0, 0, "R2 carry in set");
    do_op(1, 0, ONES, 256'd0, 0, 0, "R2 carry in clear");
  endtask

  task automatic t_sub;
    do_op(2, 0, 256'd5, 256'd7, 0, 0, "R3 negative borrow");
    do_op(2, 0, 256'd7, 256'd5, 0, 0, "R3 positive");
    do_op(2, 1, 256'd9, 256'd9, 0, 0, "R3 equal zero");
    wr_csr(12'h7C0, 32'h0000_0001);
    do_op(3, 0, 256'd9, 256'd4, 0, 0, "R3 sub borrow in");
    do_op(3, 0, 256'd4, 256'd4, 0, 0, "R3 sub no borrow");
  endtask

  task automatic t_idle;
    logic [255:0] r0 = res_q;
    logic [7:0] f0 = flags_o;
    @(negedge clk);
    op_kind = 0; op_a = ONES; op_b = ONES; op_grp = 1;
    @(negedge clk);
    chk("R4 no update when idle", {248'h0, flags_o}, {248'h0, f0});
    chk("R12 result held", res_q, r0);
    chk("R12 valid low", {255'h0, res_valid}, 0);
  endtask

  task automatic t_shift;
    logic [255:0] pat = {32{8'h00}} | {8'hC3, {30{8'h11}}, 8'h7E};
    do_op(0, 0, 256'd0, pat, 0, 1, "R5 left one byte");
    do_op(0, 0, 256'd0, pat, 1, 31, "R5 right 31 bytes");
    do_op(0, 1, 256'd1, pat, 1, 0, "R5 zero shift");
    do_op(0, 0, 256'd0, pat, 0, 31, "R5 left 31 bytes");
  endtask

  task automatic t_mod;
    logic [255:0] m = ONES - 256'd158;
    logic [7:0] f0;
    @(negedge clk); wide_we = 1; wide_wdata = m;
    @(negedge clk); wide_we = 0; exp_mod = m;
    chk("R11 wide write", mod_o, m);
    rd_csr(12'h7D3, m[127:96], "R11 word read");
    wr_csr(12'h7D0, 32'h1234_5678);
    chk("R11 word write", mod_o, exp_mod);
    rd_csr(12'h7D0, 32'h1234_5678, "R11 word readback");
    rd_csr(12'h7E0, 32'h0, "R11 other address");
    f0 = flags_o;
    do_op(4, 0, 256'd3, 256'd4, 0, 0, "R6 below modulus");
    do_op(4, 0, exp_mod - 256'd1, 256'd1, 0, 0, "R6 equal modulus");
    do_op(4, 1, exp_mod - 256'd1, exp_mod - 256'd2, 0, 0, "R6 overflow 256");
    do_op(5, 0, 256'd9, 256'd4, 0, 0, "R7 no correction");
    do_op(5, 1, 256'd4, 256'd9, 0, 0, "R7 corrected");
    chk("R8 flags untouched", {248'h0, flags_o}, {248'h0, f0});
  endtask

  task automatic t_prio;
    do_op(0, 0, ONES, 256'd1, 0, 0, "R10 write wins", 1, 8'hA5);
    rd_csr(12'h7C0, 32'hA5, "R9 packed readback");
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #12; t_reset;
    @(negedge clk); rst_n = 1;
    t_add; t_addc; t_sub; t_idle; t_shift; t_mod; t_prio;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule